// File: doc/BRIEF.md
# Two-Group Interrupt Status and Mask Unit

This block collects interrupt pulses from peripherals into two independent groups. One group serves general-purpose sources and the other serves DMA channel events. A pulse on a source line latches a sticky pending bit. A per-group mask then decides which pending bits may raise that group's exception request toward the processor. Each request is a registered level. It carries a fixed exception vector code, so the processor's exception logic knows which handler to enter.

The DMA group has two extra rules. One pending bit, the highest in the group by default, raises the request even when its mask bit is clear. The whole DMA request is also held off unless a master enable bit is set and the suspend byte of a separate enable register differs from one. When the general request rises while general pending bit 1 is set, the block sends a one-cycle strobe to the timer block so that it freezes the counts of timers 0 and 1.

A small register port gives software read access to every register. Software writes the masks and the control registers directly and clears pending bits by writing ones to them.

Top module: `irq_unit`

## Requirements
- R1: A high level on general line n (or DMA line n) during a clock edge sets general pending bit n (DMA pending bit n). The bit stays set until it is cleared. General pending reads at address 0 and DMA pending reads in bits 15:0 of address 2.
- R2: The general request is high exactly when (general pending AND general mask) was nonzero at the previous edge. A pending bit whose mask bit is clear never raises it. The general mask is written and read at address 1.
- R3: Writing address 0 clears every general pending bit whose write-data bit is 1. Writing address 2 clears every DMA pending bit whose write-data bit in 15:0 is 1, and loads the DMA mask from bits 31:16, which read back in bits 31:16.
- R4: The DMA request is high when (DMA pending AND DMA mask) is nonzero, or when DMA pending bit 15 is set whatever its mask bit holds.
- R5: The DMA request is held low while control bit 0 (address 4) is 0, or while bits 23:16 of the enable register (address 3) equal 1.
- R6: The timer hold output pulses high for one cycle, in the cycle the general request rises, when general pending bit 1 was set at the edge that raised it.
- R7: While a request is high, its vector output reads 0x400 for the general group and 0x800 for the DMA group. Otherwise the vector output reads 0.
- R8: After reset, all pending and mask bits are 0, the enable register reads 0x1201, the control register reads 0, and all outputs are low.
- R9: If a write-one clear and a new pulse hit the same pending bit at the same edge, the bit ends set.
- R10: A request rises at the second edge after the pulse is sampled. It falls at the edge after the one where the unmasked pending bits become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gen_irq_i | input | GEN_W | General-group source lines |
| dma_irq_i | input | DMA_W | DMA-group source lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| gen_req_o | output | 1 | General exception request |
| gen_vec_o | output | 12 | General exception vector code |
| dma_req_o | output | 1 | DMA exception request |
| dma_vec_o | output | 12 | DMA exception vector code |
| timer_hold_o | output | 1 | One-cycle strobe to freeze timers 0 and 1 |

## Verification
Pending bits and register contents are due at the first edge after a pulse or write, and the bench reads them back at the falling edge that follows. Requests, vector codes and the timer strobe are due one edge later, because they are registered from the pending state. The bench's reference model updates at the same edges with nonblocking assignments, so each comparison at a falling edge already carries the one-edge lag. Directed phases count edges explicitly to check that a request is still low after one edge and high after two, and that it drops one edge after a clear.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

   localparam int unsigned REG_W      = 32;
   localparam int unsigned ADDR_W     = 3;
   localparam int unsigned VEC_W      = 12;

   // register addresses
   localparam logic [ADDR_W-1:0] A_GEN_STAT = 3'd0;
   localparam logic [ADDR_W-1:0] A_GEN_MASK = 3'd1;
   localparam logic [ADDR_W-1:0] A_DMA_REG  = 3'd2;
   localparam logic [ADDR_W-1:0] A_ENABLE   = 3'd3;
   localparam logic [ADDR_W-1:0] A_CTRL     = 3'd4;

   localparam logic [REG_W-1:0] ENABLE_RST  = 32'h0000_1201;
   localparam logic [VEC_W-1:0] GEN_VEC     = 12'h400;
   localparam logic [VEC_W-1:0] DMA_VEC     = 12'h800;

   typedef struct packed {
      logic                  we;
      logic [ADDR_W-1:0]     addr;
      logic [REG_W-1:0]      data;
   } reg_wr_t;

endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   input  logic         mask_we_i,
   input  logic [W-1:0] mask_d_i,
   output logic [W-1:0] stat_o,
   output logic [W-1:0] mask_o
);

   generate
      if (W < 1 || W > 32) begin : g_bad_width
         $error("irq_stat_bank: W must be 1..32");
      end
   endgenerate

   logic [W-1:0] stat_q, mask_q;

   // a new pulse outranks a clear on the same bit
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stat_q <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_i) | set_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= '0;
      end else if (mask_we_i) begin
         mask_q <= mask_d_i;
      end
   end

   assign stat_o = stat_q;
   assign mask_o = mask_q;

endmodule

// File: rtl/irq_req_stage.sv
module irq_req_stage
   import irq_unit_pkg::*;
#(
   parameter int unsigned      W          = 16,
   parameter logic [VEC_W-1:0] VEC        = GEN_VEC,
   parameter bit               FORCE_EN   = 1'b0,
   parameter int unsigned      FORCE_BIT  = 0,
   parameter bit               STROBE_EN  = 1'b0,
   parameter int unsigned      STROBE_BIT = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [W-1:0]     stat_i,
   input  logic [W-1:0]     mask_i,
   input  logic             gate_i,
   output logic             req_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             strobe_o
);

   generate
      if (FORCE_EN && FORCE_BIT >= W) begin : g_bad_force
         $error("irq_req_stage: FORCE_BIT out of range");
      end
      if (STROBE_EN && STROBE_BIT >= W) begin : g_bad_strobe
         $error("irq_req_stage: STROBE_BIT out of range");
      end
   endgenerate

   logic hit_masked, hit_any, req_d, req_q;

   assign hit_masked = |(stat_i & mask_i);

   generate
      if (FORCE_EN) begin : g_force
         assign hit_any = hit_masked | stat_i[FORCE_BIT];
      end else begin : g_plain
         assign hit_any = hit_masked;
      end
   endgenerate

   assign req_d = hit_any & gate_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q <= 1'b0;
      else         req_q <= req_d;
   end

   generate
      if (STROBE_EN) begin : g_strobe
         logic strb_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) strb_q <= 1'b0;
            else         strb_q <= req_d & ~req_q & stat_i[STROBE_BIT];
         end
         assign strobe_o = strb_q;
      end else begin : g_no_strobe
         assign strobe_o = 1'b0;
      end
   endgenerate

   assign req_o = req_q;
   assign vec_o = req_q ? VEC : '0;

endmodule

// File: rtl/irq_unit.sv
module irq_unit
   import irq_unit_pkg::*;
#(
   parameter int unsigned GEN_W     = 16,
   parameter int unsigned DMA_W     = 16,
   parameter int unsigned DMA_FORCE = 15,
   parameter int unsigned TMR_BIT   = 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [GEN_W-1:0]    gen_irq_i,
   input  logic [DMA_W-1:0]    dma_irq_i,
   input  logic                reg_wr_i,
   input  logic [ADDR_W-1:0]   reg_addr_i,
   input  logic [REG_W-1:0]    reg_wdata_i,
   output logic [REG_W-1:0]    reg_rdata_o,
   output logic                gen_req_o,
   output logic [VEC_W-1:0]    gen_vec_o,
   output logic                dma_req_o,
   output logic [VEC_W-1:0]    dma_vec_o,
   output logic                timer_hold_o
);

   localparam int unsigned HALF = REG_W / 2;

   generate
      if (GEN_W < 2 || GEN_W > REG_W) begin : g_bad_gen
         $error("irq_unit: GEN_W must be 2..32");
      end
      if (DMA_W < 1 || DMA_W > HALF) begin : g_bad_dma
         $error("irq_unit: DMA_W must be 1..16");
      end
   endgenerate

   reg_wr_t wr;
   assign wr.we   = reg_wr_i;
   assign wr.addr = reg_addr_i;
   assign wr.data = reg_wdata_i;

   logic wr_gstat, wr_gmask, wr_dma, wr_en, wr_ctl;
   assign wr_gstat = wr.we && (wr.addr == A_GEN_STAT);
   assign wr_gmask = wr.we && (wr.addr == A_GEN_MASK);
   assign wr_dma   = wr.we && (wr.addr == A_DMA_REG);
   assign wr_en    = wr.we && (wr.addr == A_ENABLE);
   assign wr_ctl   = wr.we && (wr.addr == A_CTRL);

   logic [GEN_W-1:0] gen_clr, gen_stat, gen_mask;
   logic [DMA_W-1:0] dma_clr, dma_stat, dma_mask;

   assign gen_clr = wr_gstat ? wr.data[GEN_W-1:0] : '0;
   assign dma_clr = wr_dma   ? wr.data[DMA_W-1:0] : '0;

   irq_stat_bank #(.W(GEN_W)) u_gen_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (gen_irq_i),
      .clr_i     (gen_clr),
      .mask_we_i (wr_gmask),
      .mask_d_i  (wr.data[GEN_W-1:0]),
      .stat_o    (gen_stat),
      .mask_o    (gen_mask)
   );

   irq_stat_bank #(.W(DMA_W)) u_dma_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (dma_irq_i),
      .clr_i     (dma_clr),
      .mask_we_i (wr_dma),
      .mask_d_i  (wr.data[HALF +: DMA_W]),
      .stat_o    (dma_stat),
      .mask_o    (dma_mask)
   );

   logic [REG_W-1:0] enable_q;
   logic             ctl_en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) enable_q <= ENABLE_RST;
      else if (wr_en) enable_q <= wr.data;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctl_en_q <= 1'b0;
      else if (wr_ctl) ctl_en_q <= wr.data[0];
   end

   logic dma_gate;
   assign dma_gate = ctl_en_q && (enable_q[23:16] != 8'h01);

   irq_req_stage #(
      .W(GEN_W), .VEC(GEN_VEC), .FORCE_EN(1'b0), .FORCE_BIT(0),
      .STROBE_EN(1'b1), .STROBE_BIT(TMR_BIT)
   ) u_gen_req (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .stat_i   (gen_stat),
      .mask_i   (gen_mask),
      .gate_i   (1'b1),
      .req_o    (gen_req_o),
      .vec_o    (gen_vec_o),
      .strobe_o (timer_hold_o)
   );

   logic dma_strobe_unused;

   irq_req_stage #(
      .W(DMA_W), .VEC(DMA_VEC), .FORCE_EN(1'b1), .FORCE_BIT(DMA_FORCE),
      .STROBE_EN(1'b0), .STROBE_BIT(0)
   ) u_dma_req (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .stat_i   (dma_stat),
      .mask_i   (dma_mask),
      .gate_i   (dma_gate),
      .req_o    (dma_req_o),
      .vec_o    (dma_vec_o),
      .strobe_o (dma_strobe_unused)
   );

   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_addr_i)
         A_GEN_STAT: reg_rdata_o[GEN_W-1:0]     = gen_stat;
         A_GEN_MASK: reg_rdata_o[GEN_W-1:0]     = gen_mask;
         A_DMA_REG: begin
            reg_rdata_o[DMA_W-1:0]     = dma_stat;
            reg_rdata_o[HALF +: DMA_W] = dma_mask;
         end
         A_ENABLE:   reg_rdata_o                = enable_q;
         A_CTRL:     reg_rdata_o[0]             = ctl_en_q;
         default:    reg_rdata_o                = '0;
      endcase
   end

endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk
   import irq_unit_pkg::*;
#(
   parameter int unsigned GEN_W     = 16,
   parameter int unsigned DMA_W     = 16,
   parameter int unsigned DMA_FORCE = 15
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [GEN_W-1:0] gen_irq_i,
   input logic [DMA_W-1:0] dma_irq_i,
   input logic [GEN_W-1:0] gen_stat,
   input logic [GEN_W-1:0] gen_mask,
   input logic [DMA_W-1:0] dma_stat,
   input logic [DMA_W-1:0] dma_mask,
   input logic             dma_gate,
   input logic             gen_req_o,
   input logic [VEC_W-1:0] gen_vec_o,
   input logic             dma_req_o,
   input logic [VEC_W-1:0] dma_vec_o,
   input logic             timer_hold_o
);

   // R1 and R9: a pulsed line is pending after the edge, even under a clear
   a_r1_pulse_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gen_irq_i != '0) |=> ((gen_stat & $past(gen_irq_i)) == $past(gen_irq_i)));

   a_r9_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dma_irq_i != '0) |=> ((dma_stat & $past(dma_irq_i)) == $past(dma_irq_i)));

   // R2: nothing unmasked pending means no general request next cycle
   a_r2_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((gen_stat & gen_mask) == '0) |=> !gen_req_o);

   // R4: the forced bit raises the DMA request when the group is open
   a_r4_force_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dma_stat[DMA_FORCE] && dma_gate) |=> dma_req_o);

   // R5: closed gate means no DMA request next cycle
   a_r5_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dma_gate |=> !dma_req_o);

   // R6: the strobe only comes with a rising general request
   a_r6_strobe_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timer_hold_o |-> (gen_req_o && !$past(gen_req_o)));

   // R7: vector codes follow the requests
   a_r7_gen_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gen_req_o |-> (gen_vec_o == GEN_VEC));

   a_r7_dma_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_req_o |-> (dma_vec_o == DMA_VEC));

   // R10: an unmasked pending bit raises the general request one edge later
   a_r10_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((gen_stat & gen_mask) != '0) |=> gen_req_o);

endmodule

bind irq_unit irq_unit_chk #(
   .GEN_W(GEN_W), .DMA_W(DMA_W), .DMA_FORCE(DMA_FORCE)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .gen_irq_i    (gen_irq_i),
   .dma_irq_i    (dma_irq_i),
   .gen_stat     (gen_stat),
   .gen_mask     (gen_mask),
   .dma_stat     (dma_stat),
   .dma_mask     (dma_mask),
   .dma_gate     (dma_gate),
   .gen_req_o    (gen_req_o),
   .gen_vec_o    (gen_vec_o),
   .dma_req_o    (dma_req_o),
   .dma_vec_o    (dma_vec_o),
   .timer_hold_o (timer_hold_o)
);

// File: tb/sim_irq_unit.sv
`timescale 1ns/1ps
module sim_irq_unit;

   localparam int GW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [GW-1:0] gen_irq = '0;
   logic [DW-1:0] dma_irq = '0;
   logic          wr = 1'b0;
   logic [2:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          greq, dreq, hold;
   logic [11:0]   gvec, dvec;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   irq_unit u0 (
      .clk_i(clk), .rst_ni(rst_n), .gen_irq_i(gen_irq), .dma_irq_i(dma_irq),
      .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .gen_req_o(greq), .gen_vec_o(gvec), .dma_req_o(dreq), .dma_vec_o(dvec),
      .timer_hold_o(hold)
   );

   // reference model
   logic [GW-1:0] m_gs, m_gm;
   logic [DW-1:0] m_ds, m_dm;
   logic [31:0]   m_en;
   logic          m_ctl, m_greq, m_dreq, m_hold;

   function automatic logic f_dma_req(logic [DW-1:0] s, logic [DW-1:0] m,
                                      logic c, logic [31:0] e);
      return (((s & m) != '0) || s[15]) && c && (e[23:16] != 8'h01);
   endfunction

   function automatic logic [31:0] f_read(logic [2:0] a);
      case (a)
         3'd0: return {16'h0, m_gs};
         3'd1: return {16'h0, m_gm};
         3'd2: return {m_dm, m_ds};
         3'd3: return m_en;
         3'd4: return {31'h0, m_ctl};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_gs <= '0; m_gm <= '0; m_ds <= '0; m_dm <= '0;
         m_en <= 32'h1201; m_ctl <= 1'b0;
         m_greq <= 1'b0; m_dreq <= 1'b0; m_hold <= 1'b0;
      end else begin
         m_gs <= (m_gs & ~((wr && addr == 3'd0) ? wdata[15:0] : 16'h0)) | gen_irq;
         m_ds <= (m_ds & ~((wr && addr == 3'd2) ? wdata[15:0] : 16'h0)) | dma_irq;
         if (wr && addr == 3'd1) m_gm <= wdata[15:0];
         if (wr && addr == 3'd2) m_dm <= wdata[31:16];
         if (wr && addr == 3'd3) m_en <= wdata;
         if (wr && addr == 3'd4) m_ctl <= wdata[0];
         m_greq <= (m_gs & m_gm) != '0;
         m_hold <= ((m_gs & m_gm) != '0) && !m_greq && m_gs[1];
         m_dreq <= f_dma_req(m_ds, m_dm, m_ctl, m_en);
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cmp_all();
      chk(greq == m_greq, "R2 gen request", greq, m_greq);
      chk(dreq == m_dreq, "R4/R5 dma request R4 R5", dreq, m_dreq);
      chk(hold == m_hold, "R6 timer hold", hold, m_hold);
      chk(gvec == (m_greq ? 12'h400 : 12'h0), "R7 gen vector", gvec,
          m_greq ? 12'h400 : 12'h0);
      chk(dvec == (m_dreq ? 12'h800 : 12'h0), "R7 dma vector", dvec,
          m_dreq ? 12'h800 : 12'h0);
      chk(rdata == f_read(addr), "R1/R3 read back R1 R3", rdata, f_read(addr));
   endtask

   // one edge, then compare at the falling edge, then release strobes
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      cmp_all();
      wr = 1'b0; gen_irq = '0; dma_irq = '0;
   endtask

   task automatic wreg(input logic [2:0] a, input logic [31:0] d);
      wr = 1'b1; addr = a; wdata = d;
      step();
   endtask

   initial begin
      #(20ns * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      addr = 3'd3;
      #1 chk(rdata == 32'h1201, "R8 enable reset", rdata, 32'h1201);
      chk(!greq && !dreq && !hold && gvec == 0 && dvec == 0, "R8 outputs low",
          {greq, dreq, hold}, 0);
      addr = 3'd0;
      #1 chk(rdata == 0, "R8 gen pending reset", rdata, 0);

      // R2 masked pulse raises nothing
      gen_irq = 16'h0004; step();
      step();
      chk(!greq, "R2 masked no request", greq, 0);

      // R10 latency and R6 strobe
      wreg(3'd1, 32'h0000_0002);
      step();
      gen_irq = 16'h0002; step();
      chk(!greq, "R10 low after one edge", greq, 0);
      step();
      chk(greq && hold, "R10/R6 rise R10 R6", {greq, hold}, 2'b11);
      step();
      chk(greq && !hold, "R6 one cycle strobe", {greq, hold}, 2'b10);
      wreg(3'd0, 32'h0000_0002);
      chk(greq, "R10 still high at clear edge", greq, 1);
      step();
      chk(!greq, "R10 drop one edge after zero", greq, 0);

      // R9 set beats clear on the same bit
      addr = 3'd0; wr = 1'b1; wdata = 32'h0000_0010; gen_irq = 16'h0010;
      step();
      addr = 3'd0;
      #1 chk(rdata[4] == 1'b1, "R9 set wins", rdata, 32'h10);

      // R4 forced bit with mask clear, R5 gating
      wreg(3'd4, 32'h1);
      dma_irq = 16'h8000; step();
      step();
      chk(dreq && dvec == 12'h800, "R4 force bit unmasked", dvec, 12'h800);
      wreg(3'd3, 32'h0001_0000);
      step();
      chk(!dreq, "R5 suspend byte one", dreq, 0);
      wreg(3'd3, 32'h0002_0000);
      step();
      chk(dreq, "R5 suspend byte two", dreq, 1);
      wreg(3'd4, 32'h0);
      step();
      chk(!dreq, "R5 master enable off", dreq, 0);
      wreg(3'd4, 32'h1);
      wreg(3'd2, 32'h0000_8000);
      step();
      chk(!dreq, "R3 dma clear", dreq, 0);

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         r = $urandom;
         gen_irq = (r[3:0] == 0) ? 16'(1 << $urandom_range(15, 0)) : '0;
         dma_irq = (r[7:4] == 0) ? 16'(1 << $urandom_range(15, 0)) : '0;
         addr    = 3'($urandom_range(5, 0));
         wr      = (r[10:8] == 0);
         wdata   = $urandom;
         if (addr == 3'd4) wdata[0] = (r[13:11] != 0);
         if (addr == 3'd3 && r[14]) wdata[23:16] = 8'h01;
         step();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule